// File: doc/BRIEF.md
# Cascaded Interrupt Vector Acknowledge Unit

This block sits between a processor interrupt-acknowledge request and a pair of eight-line interrupt controllers. One controller is the primary and the other is the secondary. The secondary controller's request output is wired to input line 2 of the primary. Each controller reports whether it has a winning line and which line that is, and each supplies a programmed vector base. Each controller resolves its own priority; this block does not.

When the acknowledge request arrives, the unit looks at the primary's winner. If the primary has no winner, the result is spurious: the unit returns the primary base plus line 7 and strobes neither controller. If the primary's winner is an ordinary line, the unit returns the primary base plus that line and strobes only the primary. If the primary's winner is the cascade line, the unit consults the secondary. It returns the secondary base plus the secondary's line, or plus line 7 when the secondary has no winner. In both cascade cases it strobes the primary on line 2, and it strobes the secondary only when the secondary had a real winner.

All results are registered. The acknowledge strobes, their line numbers and the vector with its valid pulse all appear on the cycle after the request. The vector output is a valid-only stream with no ready. The consumer must take the vector during the single cycle in which `vec_valid` is high, because the unit never stalls or repeats a vector. Between pulses, `vec_data` keeps the last value it delivered.

Top module: `cascade_ack_unit`

## Requirements
- R1: When the primary has a winner on a line other than 2, the vector is {primary base[7:3], line}. The primary is strobed with that line, and the secondary is not strobed.
- R2: When the primary winner is line 2 and the secondary has a winner, the vector is {secondary base[7:3], secondary line}, and the secondary is strobed with its line.
- R3: When the primary winner is line 2 and the secondary has no winner, the vector is {secondary base[7:3], 3'b111}, and the secondary is not strobed.
- R4: In both cascade cases the primary is strobed with line number 2.
- R5: When the primary has no winner, the vector is {primary base[7:3], 3'b111} and neither controller is strobed, whatever the secondary reports.
- R6: Bits [2:0] of either programmed base have no effect on the vector.
- R7: A request sampled high at a rising edge produces `vec_valid` and any acknowledge strobes for exactly the following cycle. No strobe or valid appears without a request.
- R8: During and after reset, `vec_valid`, `pri_ack` and `sec_ack` are low and `vec_data` is zero.
- R9: `vec_data` holds its value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Single-cycle acknowledge request from the processor |
| pri_win_valid | input | 1 | Primary controller has a winning line |
| pri_win_line | input | 3 | Primary winning line index |
| sec_win_valid | input | 1 | Secondary controller has a winning line |
| sec_win_line | input | 3 | Secondary winning line index |
| pri_base | input | 8 | Primary programmed vector base |
| sec_base | input | 8 | Secondary programmed vector base |
| pri_ack | output | 1 | Acknowledge strobe to the primary |
| pri_ack_line | output | 3 | Line being acknowledged on the primary |
| sec_ack | output | 1 | Acknowledge strobe to the secondary |
| sec_ack_line | output | 3 | Line being acknowledged on the secondary |
| vec_valid | output | 1 | Vector valid pulse (no back-pressure) |
| vec_data | output | 8 | Returned interrupt vector |

## Verification
Every result (vector, valid pulse, both strobes and their line numbers) is due exactly one rising edge after the edge that samples `ack_req`. The bench drives inputs on a falling edge and holds the request for one cycle. It checks all outputs on the next falling edge, then checks again one cycle later, when the strobes and valid must be low and the vector must be unchanged. Because every sample falls halfway between edges, no check depends on the order in which processes run at an edge.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
  typedef enum logic [1:0] {
    ROUTE_SPURIOUS_PRI = 2'd0,
    ROUTE_PRIMARY      = 2'd1,
    ROUTE_SECONDARY    = 2'd2,
    ROUTE_SPURIOUS_SEC = 2'd3
  } route_e;
endpackage

// File: rtl/cack_route.sv
module cack_route
  import cascade_ack_pkg::*;
#(
  parameter int LINES        = 8,
  parameter int CASCADE_LINE = 2,
  parameter int SPUR_LINE    = 7,
  localparam int IDX_W       = $clog2(LINES)
) (
  input  logic             pri_valid,
  input  logic [IDX_W-1:0] pri_line,
  input  logic             sec_valid,
  input  logic [IDX_W-1:0] sec_line,
  output route_e           route,
  output logic [IDX_W-1:0] vec_line,
  output logic             pri_fire,
  output logic [IDX_W-1:0] pri_fire_line,
  output logic             sec_fire,
  output logic [IDX_W-1:0] sec_fire_line
);
  localparam logic [IDX_W-1:0] CASC = IDX_W'(CASCADE_LINE);
  localparam logic [IDX_W-1:0] SPUR = IDX_W'(SPUR_LINE);

  always_comb begin
    route         = ROUTE_SPURIOUS_PRI;
    vec_line      = SPUR;
    pri_fire      = 1'b0;
    pri_fire_line = '0;
    sec_fire      = 1'b0;
    sec_fire_line = '0;
    if (pri_valid) begin
      pri_fire      = 1'b1;
      pri_fire_line = pri_line;
      if (pri_line == CASC) begin
        if (sec_valid) begin
          route         = ROUTE_SECONDARY;
          vec_line      = sec_line;
          sec_fire      = 1'b1;
          sec_fire_line = sec_line;
        end else begin
          route    = ROUTE_SPURIOUS_SEC;
          vec_line = SPUR;
        end
      end else begin
        route    = ROUTE_PRIMARY;
        vec_line = pri_line;
      end
    end
  end
endmodule

// File: rtl/cack_vector.sv
module cack_vector
  import cascade_ack_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int NCTRL = 2
) (
  input  route_e           route,
  input  logic [IDX_W-1:0] line,
  input  logic [VEC_W-1:0] pri_base,
  input  logic [VEC_W-1:0] sec_base,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0]       bases   [NCTRL];
  logic [VEC_W-IDX_W-1:0] aligned [NCTRL];

  assign bases[0] = pri_base;
  assign bases[1] = sec_base;

  for (genvar g = 0; g < NCTRL; g++) begin : g_align
    assign aligned[g] = bases[g][VEC_W-1:IDX_W];
  end

  always_comb begin
    if (route == ROUTE_SECONDARY || route == ROUTE_SPURIOUS_SEC)
      vec = {aligned[1], line};
    else
      vec = {aligned[0], line};
  end
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit
  import cascade_ack_pkg::*;
#(
  parameter int LINES        = 8,
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2,
  parameter int SPUR_LINE    = 7,
  localparam int IDX_W       = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_req,
  input  logic             pri_win_valid,
  input  logic [IDX_W-1:0] pri_win_line,
  input  logic             sec_win_valid,
  input  logic [IDX_W-1:0] sec_win_line,
  input  logic [VEC_W-1:0] pri_base,
  input  logic [VEC_W-1:0] sec_base,
  output logic             pri_ack,
  output logic [IDX_W-1:0] pri_ack_line,
  output logic             sec_ack,
  output logic [IDX_W-1:0] sec_ack_line,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  route_e           route;
  logic [IDX_W-1:0] vline;
  logic             pfire, sfire;
  logic [IDX_W-1:0] pline, sline;
  logic [VEC_W-1:0] vec_next;

  cack_route #(
    .LINES(LINES), .CASCADE_LINE(CASCADE_LINE), .SPUR_LINE(SPUR_LINE)
  ) route_i (
    .pri_valid(pri_win_valid), .pri_line(pri_win_line),
    .sec_valid(sec_win_valid), .sec_line(sec_win_line),
    .route(route), .vec_line(vline),
    .pri_fire(pfire), .pri_fire_line(pline),
    .sec_fire(sfire), .sec_fire_line(sline)
  );

  cack_vector #(.LINES(LINES), .VEC_W(VEC_W)) vector_i (
    .route(route), .line(vline),
    .pri_base(pri_base), .sec_base(sec_base),
    .vec(vec_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_ack      <= 1'b0;
      pri_ack_line <= '0;
      sec_ack      <= 1'b0;
      sec_ack_line <= '0;
      vec_valid    <= 1'b0;
      vec_data     <= '0;
    end else begin
      pri_ack   <= ack_req & pfire;
      sec_ack   <= ack_req & sfire;
      vec_valid <= ack_req;
      if (ack_req) begin
        pri_ack_line <= pline;
        sec_ack_line <= sline;
        vec_data     <= vec_next;
      end
    end
  end

  // R7: valid pulse follows each request, and nothing appears without one
  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> vec_valid);
  a_r7_no_unrequested_out: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> (!vec_valid && !pri_ack && !sec_ack));
  // R2/R4: a secondary strobe always comes with a primary strobe on the cascade line
  a_r4_sec_needs_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ack |-> (pri_ack && pri_ack_line == IDX_W'(CASCADE_LINE)));
  // R5: no primary winner gives the spurious line and no strobes
  a_r5_spurious_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !pri_win_valid) |=>
      (!pri_ack && !sec_ack && vec_data[IDX_W-1:0] == IDX_W'(SPUR_LINE)));
  // R3: cascade with no secondary winner leaves the secondary unstrobed
  a_r3_spurious_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && pri_win_valid && pri_win_line == IDX_W'(CASCADE_LINE) && !sec_win_valid)
      |=> (!sec_ack && vec_data[IDX_W-1:0] == IDX_W'(SPUR_LINE)));
  // R9: vector holds without a request
  a_r9_vector_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> $stable(vec_data));
  // R6: the low bits of the vector never come from the base
  a_r6_base_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && pri_win_valid && pri_win_line != IDX_W'(CASCADE_LINE))
      |=> (vec_data[IDX_W-1:0] == $past(pri_win_line)));
endmodule

// File: tb/cascade_ack_unit_tb.sv
module cascade_ack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_req = 1'b0;
  logic       pv = 1'b0, sv = 1'b0;
  logic [2:0] pl = '0, sl = '0;
  logic [7:0] pb = '0, sb = '0;
  logic       pri_ack, sec_ack, vec_valid;
  logic [2:0] pri_ack_line, sec_ack_line;
  logic [7:0] vec_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_ack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .pri_win_valid(pv), .pri_win_line(pl),
    .sec_win_valid(sv), .sec_win_line(sl),
    .pri_base(pb), .sec_base(sb),
    .pri_ack(pri_ack), .pri_ack_line(pri_ack_line),
    .sec_ack(sec_ack), .sec_ack_line(sec_ack_line),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Request with given inputs; check the result cycle and the cycle after.
  task automatic do_ack(input logic v1, input logic [2:0] l1, input logic v2,
                        input logic [2:0] l2, input logic [7:0] b1, input logic [7:0] b2,
                        input string tag, input int exp_vec, input int exp_pa,
                        input int exp_pl, input int exp_sa, input int exp_sl);
    @(negedge clk);
    pv = v1; pl = l1; sv = v2; sl = l2; pb = b1; sb = b2; ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    chk({tag, " R7 valid"}, vec_valid, 1);
    chk({tag, " vector"}, vec_data, exp_vec);
    chk({tag, " pri ack"}, pri_ack, exp_pa);
    if (exp_pa != 0) chk({tag, " pri line"}, pri_ack_line, exp_pl);
    chk({tag, " sec ack"}, sec_ack, exp_sa);
    if (exp_sa != 0) chk({tag, " sec line"}, sec_ack_line, exp_sl);
    @(negedge clk);
    chk({tag, " R7 single pulse"}, {vec_valid, pri_ack, sec_ack}, 0);
    chk({tag, " R9 hold"}, vec_data, exp_vec);
  endtask

  task automatic t_reset();
    chk("R8 valid", vec_valid, 0);
    chk("R8 pri_ack", pri_ack, 0);
    chk("R8 sec_ack", sec_ack, 0);
    chk("R8 vec", vec_data, 0);
  endtask

  task automatic t_primary();
    do_ack(1, 3'd5, 0, 3'd0, 8'h20, 8'h70, "R1 line5", 8'h25, 1, 5, 0, 0);
    do_ack(1, 3'd0, 1, 3'd4, 8'h08, 8'h70, "R1 line0", 8'h08, 1, 0, 0, 0);
    do_ack(1, 3'd7, 1, 3'd1, 8'hF8, 8'h70, "R1 line7", 8'hFF, 1, 7, 0, 0);
  endtask

  task automatic t_cascade();
    do_ack(1, 3'd2, 1, 3'd3, 8'h08, 8'h70, "R2 R4 slave3", 8'h73, 1, 2, 1, 3);
    do_ack(1, 3'd2, 1, 3'd0, 8'h08, 8'h70, "R2 R4 slave0", 8'h70, 1, 2, 1, 0);
    do_ack(1, 3'd2, 0, 3'd5, 8'h08, 8'h70, "R3 R4 spurious slave", 8'h77, 1, 2, 0, 0);
  endtask

  task automatic t_spurious_primary();
    do_ack(0, 3'd2, 1, 3'd3, 8'h08, 8'h70, "R5 no winner", 8'h0F, 0, 0, 0, 0);
    do_ack(0, 3'd4, 0, 3'd0, 8'h40, 8'h70, "R5 no winner b40", 8'h47, 0, 0, 0, 0);
  endtask

  task automatic t_base_low();
    do_ack(1, 3'd1, 0, 3'd0, 8'h27, 8'h00, "R6 pri base", 8'h21, 1, 1, 0, 0);
    do_ack(1, 3'd2, 1, 3'd6, 8'h00, 8'h75, "R6 sec base", 8'h76, 1, 2, 1, 6);
  endtask

  task automatic t_idle_inputs();
    @(negedge clk);
    pv = 1; pl = 3'd6; sv = 1; sl = 3'd1; pb = 8'hA0; sb = 8'hB0;
    repeat (3) @(negedge clk);
    chk("R7 idle no output", {vec_valid, pri_ack, sec_ack}, 0);
    chk("R9 idle vector", vec_data, 8'h76);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_cascade();
    t_spurious_primary();
    t_base_low();
    t_idle_inputs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule